// File: doc/BRIEF.md
# Threshold-Priority Two-Channel DMA Arbiter

Two DMA channels share one host bus, and this block decides which of them owns it. Each channel has its own data FIFO. It reports how many bytes that FIFO holds, which direction it is moving data, and two 6-bit thresholds: one applies when the FIFO drains toward the host, the other when the FIFO fills from the host. The arbiter turns these into a one-bit priority for each channel. A draining channel is urgent when its FIFO holds more dwords than its drain threshold. A filling channel is urgent when its free space in dwords exceeds its fill threshold.

Grants are sticky. An owner keeps the bus against a rival of equal or lower priority. A rival with strictly higher priority makes the arbiter send the owner a one-cycle terminate pulse. The bus then moves once the owner acknowledges the pulse or drops its request. When both channels ask from idle with equal priority, the channel that owned the bus last wins. The block also presents, for each channel, a registered status word that holds the byte count and both thresholds.

Top module: `dma_pair_arbiter`

## Requirements
- R1: While reset is held, `gnt`, `term`, `status0` and `status1` are all zero, and the last-owner record is channel 0.
- R2: With `dir[i]`=1 (draining), channel i has priority 1 exactly when `fill_i`>>2 (occupied dwords) is greater than `drain_thr_i`. For example, a threshold of 0 with a byte count of 4 gives priority 1, and a threshold of 0 with a count of 0 gives priority 0.
- R3: With `dir[i]`=0 (filling), channel i has priority 1 exactly when 64 − (`fill_i`>>2) is greater than `fill_thr_i`. For example, a threshold of 63 with a count of 0 gives priority 1, and a threshold of 63 with a count of 4 gives priority 0.
- R4: When both channels request with no current owner and their priorities differ, the higher-priority channel is granted in the next cycle. At most one bit of `gnt` is ever set, and bit i stands for channel i.
- R5: When both channels request with no current owner and their priorities are equal, the channel recorded as the last owner is granted. The record is updated every time a grant is issued.
- R6: A lone requester is granted in the next cycle whatever its priority. With no requests, no grant is set.
- R7: An owner that keeps requesting keeps its grant while the other channel requests with the same or lower priority.
- R8: If the non-owner requests with strictly higher priority than a requesting owner, `term` pulses for exactly one cycle on the owner's bit. The grant stays with the owner until the cycle after `term_ack` on the owner's bit or the owner drops its request, and then moves to the other channel if it is still requesting.
- R9: When the owner drops its request, its grant clears in the next cycle, and a waiting request from the other channel is granted in that same cycle.
- R10: One cycle after the inputs are sampled, each status word holds the channel's byte count in bits 24:16, its drain threshold in bits 13:8 and its fill threshold in bits 5:0. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 2 | Bus request, bit i for channel i |
| dir | input | 2 | Transfer direction, 1 = FIFO drains to host, 0 = FIFO fills |
| term_ack | input | 2 | Owner confirms that it has ended its transaction |
| fill0 | input | 9 | Channel 0 FIFO valid byte count (0 to 256) |
| fill1 | input | 9 | Channel 1 FIFO valid byte count (0 to 256) |
| drain_thr0 | input | 6 | Channel 0 dword threshold for draining |
| fill_thr0 | input | 6 | Channel 0 dword threshold for filling |
| drain_thr1 | input | 6 | Channel 1 dword threshold for draining |
| fill_thr1 | input | 6 | Channel 1 dword threshold for filling |
| gnt | output | 2 | Bus grant, at most one bit set |
| term | output | 2 | One-cycle request to the owner to end its transaction |
| status0 | output | 32 | Channel 0 status and threshold word |
| status1 | output | 32 | Channel 1 status and threshold word |

## Verification
The hardest case to reach is a preemption that is still pending. The owner has received its terminate pulse but has not yet acknowledged it, and the bench must show that the grant does not move in that window. To get there, the stimulus first gives the bus to a low-priority lone requester. It then raises the rival's request while the rival's FIFO level already puts it above its threshold. After the pulse, it holds the acknowledge low for a cycle before asserting it. A second pass ends the pending state by having the owner drop its request instead of acknowledging.

// File: rtl/dma_pair_arbiter.sv
module dma_pair_arbiter #(
  parameter int FIFO_BYTES = 256,
  parameter int WORD_BYTES = 4,
  parameter int THR_W      = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [1:0]                         req,
  input  logic [1:0]                         dir,
  input  logic [1:0]                         term_ack,
  input  logic [$clog2(FIFO_BYTES):0]        fill0,
  input  logic [$clog2(FIFO_BYTES):0]        fill1,
  input  logic [THR_W-1:0]                   drain_thr0,
  input  logic [THR_W-1:0]                   fill_thr0,
  input  logic [THR_W-1:0]                   drain_thr1,
  input  logic [THR_W-1:0]                   fill_thr1,
  output logic [1:0]                         gnt,
  output logic [1:0]                         term,
  output logic [31:0]                        status0,
  output logic [31:0]                        status1
);
  localparam int CNT_W = $clog2(FIFO_BYTES) + 1;
  localparam int SLOTS = FIFO_BYTES / WORD_BYTES;
  localparam int OCC_W = $clog2(SLOTS) + 1;
  localparam int SHIFT = $clog2(WORD_BYTES);
  localparam int CNT_LSB = 16;
  localparam int DRN_LSB = 8;
  localparam int FIL_LSB = 0;

  function automatic logic urgent(input logic drain, input logic [CNT_W-1:0] fill,
                                  input logic [THR_W-1:0] dthr, input logic [THR_W-1:0] fthr);
    logic [OCC_W-1:0] used, room;
    used = OCC_W'(fill >> SHIFT);
    room = OCC_W'(SLOTS) - used;
    return drain ? (used > OCC_W'(dthr)) : (room > OCC_W'(fthr));
  endfunction

  logic [1:0] pri;
  assign pri[0] = urgent(dir[0], fill0, drain_thr0, fill_thr0);
  assign pri[1] = urgent(dir[1], fill1, drain_thr1, fill_thr1);

  logic own_v, own_id, last_id, pend;
  logic pick_any, pick_id, rival, preempt;

  assign pick_any = |req;
  assign pick_id  = (req == 2'b11) ? ((pri[0] != pri[1]) ? pri[1] : last_id) : req[1];
  assign rival    = ~own_id;
  assign preempt  = req[rival] & pri[rival] & ~pri[own_id];
  assign gnt      = own_v ? (own_id ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_v   <= 1'b0;
      own_id  <= 1'b0;
      last_id <= 1'b0;
      pend    <= 1'b0;
      term    <= 2'b00;
    end else begin
      term <= 2'b00;
      if (!own_v || !req[own_id]) begin
        own_v <= pick_any;
        pend  <= 1'b0;
        if (pick_any) begin
          own_id  <= pick_id;
          last_id <= pick_id;
        end
      end else if (pend) begin
        if (term_ack[own_id]) begin
          pend  <= 1'b0;
          own_v <= req[rival];
          if (req[rival]) begin
            own_id  <= rival;
            last_id <= rival;
          end
        end
      end else if (preempt) begin
        term[own_id] <= 1'b1;
        pend         <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status0 <= '0;
      status1 <= '0;
    end else begin
      status0 <= '0;
      status1 <= '0;
      status0[CNT_LSB +: CNT_W] <= fill0;
      status0[DRN_LSB +: THR_W] <= drain_thr0;
      status0[FIL_LSB +: THR_W] <= fill_thr0;
      status1[CNT_LSB +: CNT_W] <= fill1;
      status1[DRN_LSB +: THR_W] <= drain_thr1;
      status1[FIL_LSB +: THR_W] <= fill_thr1;
    end
  end

  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  a_r6_grant_from_req0: assert property (@(posedge clk) disable iff (!rst_n) gnt[0] |-> $past(req[0]));
  a_r6_grant_from_req1: assert property (@(posedge clk) disable iff (!rst_n) gnt[1] |-> $past(req[1]));
  a_r8_term_one_cycle: assert property (@(posedge clk) disable iff (!rst_n) (term != 2'b00) |=> (term == 2'b00));
  a_r8_term_to_owner: assert property (@(posedge clk) disable iff (!rst_n) (term & ~gnt) == 2'b00);
  a_r8_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && own_v && req[own_id] && !term_ack[own_id]) |=> $stable(gnt));
  a_r9_release0: assert property (@(posedge clk) disable iff (!rst_n) (gnt[0] && !req[0]) |=> !gnt[0]);
  a_r9_release1: assert property (@(posedge clk) disable iff (!rst_n) (gnt[1] && !req[1]) |=> !gnt[1]);
  a_r10_count0: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> status0[CNT_LSB +: CNT_W] == $past(fill0));
endmodule

// File: tb/dma_pair_arbiter_bench.sv
`timescale 1ns/1ps
module dma_pair_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] req = 2'b00, dir = 2'b11, ack = 2'b00;
  logic [8:0] fill0 = 9'd0, fill1 = 9'd0;
  logic [5:0] dthr0 = 6'd5, fthr0 = 6'd5, dthr1 = 6'd5, fthr1 = 6'd5;
  logic [1:0] gnt, term;
  logic [31:0] status0, status1;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_pair_arbiter u_dma_pair_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .dir(dir), .term_ack(ack),
    .fill0(fill0), .fill1(fill1),
    .drain_thr0(dthr0), .fill_thr0(fthr0), .drain_thr1(dthr1), .fill_thr1(fthr1),
    .gnt(gnt), .term(term), .status0(status0), .status1(status1));

  typedef struct packed { logic [1:0] g; logic [1:0] t; } exp_t;
  exp_t exp_q[$];
  string tag_q[$];

  function automatic logic [31:0] sword(input logic [8:0] f, input logic [5:0] d, input logic [5:0] r);
    logic [31:0] s = '0;
    s[24:16] = f; s[13:8] = d; s[5:0] = r;
    return s;
  endfunction

  task automatic go(input logic [1:0] r, input logic [1:0] a,
                    input logic [1:0] g, input logic [1:0] t, input string tag);
    @(negedge clk);
    req = r; ack = a;
    exp_q.push_back('{g: g, t: t});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      exp_t e;
      string tg;
      logic [31:0] s0, s1;
      e = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (gnt !== e.g || term !== e.t) begin
        fails++;
        $display("FAIL %s: gnt=%b term=%b expected gnt=%b term=%b", tg, gnt, term, e.g, e.t);
      end
      s0 = sword(fill0, dthr0, fthr0);
      s1 = sword(fill1, dthr1, fthr1);
      checks++;
      if (status0 !== s0 || status1 !== s1) begin
        fails++;
        $display("FAIL R10: status0=%h status1=%h expected %h %h", status0, status1, s0, s1);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: expired expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    fill0 = 9'd100; fill1 = 9'd8;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (gnt !== 2'b00 || term !== 2'b00 || status0 !== 0 || status1 !== 0) begin // R1
      fails++;
      $display("FAIL R1: gnt=%b term=%b st0=%h st1=%h expected all zero", gnt, term, status0, status1);
    end
    @(negedge clk);
    fill0 = 9'd0; fill1 = 9'd0;
    rst_n = 1'b1;
    // R6 lone requester with low priority, then none
    go(2'b00, 2'b00, 2'b00, 2'b00, "R6 idle");
    go(2'b01, 2'b00, 2'b01, 2'b00, "R6 lone ch0");
    go(2'b01, 2'b00, 2'b01, 2'b00, "R6 hold ch0");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R6 no request");
    // R1 last owner reset to 0 plus R5 equal priority after ch1 owned
    go(2'b10, 2'b00, 2'b10, 2'b00, "R6 lone ch1");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release ch1");
    go(2'b11, 2'b00, 2'b10, 2'b00, "R5 tie to last owner ch1");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release");
    // R4 ch0 higher (40 bytes = 10 dwords > 5) despite last owner ch1
    fill0 = 9'd40;
    go(2'b11, 2'b00, 2'b01, 2'b00, "R4 higher ch0 wins");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release");
    fill0 = 9'd0;
    go(2'b11, 2'b00, 2'b01, 2'b00, "R5 tie to last owner ch0");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release");
    // R3 filling direction boundaries
    dir = 2'b00; fthr0 = 6'd63; fthr1 = 6'd63; fill0 = 9'd4; fill1 = 9'd0;
    go(2'b11, 2'b00, 2'b10, 2'b00, "R3 free 64>63 beats free 63");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release");
    fill0 = 9'd0; fill1 = 9'd4;
    go(2'b11, 2'b00, 2'b01, 2'b00, "R3 ch0 free 64 wins over last owner");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release");
    // R2 draining direction with threshold 0: last owner ch0
    dir = 2'b11; dthr0 = 6'd0; dthr1 = 6'd0; fill0 = 9'd0; fill1 = 9'd4;
    go(2'b11, 2'b00, 2'b10, 2'b00, "R2 one dword > 0 wins");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release");
    fill0 = 9'd3; fill1 = 9'd0;
    go(2'b11, 2'b00, 2'b10, 2'b00, "R2 three bytes is zero dwords, tie to ch1");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release");
    // R7 owner keeps against equal and lower priority
    dthr0 = 6'd5; dthr1 = 6'd5; fill0 = 9'd0; fill1 = 9'd0;
    go(2'b01, 2'b00, 2'b01, 2'b00, "R6 ch0 owns");
    go(2'b11, 2'b00, 2'b01, 2'b00, "R7 equal rival");
    go(2'b11, 2'b00, 2'b01, 2'b00, "R7 equal rival held");
    fill0 = 9'd40;
    go(2'b11, 2'b00, 2'b01, 2'b00, "R7 lower rival");
    // R9 owner drops while rival waits
    go(2'b10, 2'b00, 2'b10, 2'b00, "R9 handoff to waiting ch1");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release");
    // R8 preemption with delayed acknowledge
    fill0 = 9'd0; fill1 = 9'd40;
    go(2'b01, 2'b00, 2'b01, 2'b00, "R6 ch0 owns low");
    go(2'b11, 2'b00, 2'b01, 2'b01, "R8 terminate pulse");
    go(2'b11, 2'b00, 2'b01, 2'b00, "R8 hold until ack");
    go(2'b11, 2'b00, 2'b01, 2'b00, "R8 still holding");
    go(2'b11, 2'b01, 2'b10, 2'b00, "R8 ack moves grant");
    go(2'b10, 2'b00, 2'b10, 2'b00, "R8 new owner");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release");
    // R8 preemption ended by the owner dropping its request
    go(2'b01, 2'b00, 2'b01, 2'b00, "R6 ch0 owns low");
    go(2'b11, 2'b00, 2'b01, 2'b01, "R8 terminate pulse");
    go(2'b10, 2'b00, 2'b10, 2'b00, "R8 drop moves grant");
    // R8 preemption of ch1 by ch0
    fill0 = 9'd40; fill1 = 9'd0;
    go(2'b11, 2'b00, 2'b10, 2'b10, "R8 terminate ch1");
    go(2'b11, 2'b10, 2'b01, 2'b00, "R8 ack moves to ch0");
    go(2'b00, 2'b00, 2'b00, 2'b00, "R9 release");
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule